// File: doc/BRIEF.md
# Power-On Reset and Configuration Strap Sequencer

This block brings a host processor out of power-on reset. It runs on the processor's system clock. While power-good is low it holds the hard reset output active and drives no straps. Once power-good rises, it captures the configuration strap word from an input port. The strap word has two groups. It drives the PLL strap group first, counting microseconds on a prescaled timebase. It then drives the remaining strap group for a fixed number of clocks and releases hard reset. After release it keeps every strap steady for a short hold window, turns all per-bit output enables off, and signals completion.

After completion the block serves soft reset requests. Each request input has its own active-low soft reset output, which pulses low for a parameterised number of clocks. Losing power-good at any point pulls hard reset active in the same cycle and sends the sequence back to its idle state.

The strap bus is split by bit position. Bits `[PLL_W-1:0]` are the PLL group and bits `[STRAP_W-1:PLL_W]` are the other group. A high output-enable bit means that strap is being driven. A low bit means that pin is left to high impedance by the pad logic.

Top module: `por_strap_seq`

## Requirements
- R1: After power-good rises, `hrst_no` stays low for at least `HRST_US` microseconds, where one microsecond is `CYC_PER_US` clocks. The low phase lasts exactly 1 + max(`HRST_US`,`PLL_SETUP_US`)·`CYC_PER_US` + `CFG_SETUP_CLKS` sampled cycles, counting from the first sample that sees power-good high.
- R2: Every PLL-group enable (bits `[PLL_W-1:0]`) is high continuously for at least `PLL_SETUP_US` microseconds before `hrst_no` rises. The exact length is max(`HRST_US`,`PLL_SETUP_US`)·`CYC_PER_US` + `CFG_SETUP_CLKS` cycles.
- R3: The other-group enables (bits above `PLL_W`) go high exactly `CFG_SETUP_CLKS` cycles before `hrst_no` rises, and not earlier.
- R4: All enables stay high, with unchanged values, on the cycle `hrst_no` rises and on the following cycle.
- R5: All enables are low from the `OE_DROP_CLKS`-th cycle after `hrst_no` rises (default 3), which is within 5 cycles of release.
- R6: A soft reset request drives its own `srst_no` bit low for exactly `SRST_CLKS` cycles, starting one cycle after the request is sampled.
- R7: When power-good is low, `hrst_no` is low in the same cycle, all enables are low from the next cycle, and the full sequence restarts when power-good returns.
- R8: A soft reset request has no effect unless `done_o` is high. A request that arrives while that channel's pulse is still running is also dropped.
- R9: `strap_val_o` holds the value of `strap_i` captured on the cycle the sequence starts. Later changes on `strap_i` do not reach it.
- R10: Under reset, `hrst_no` and `done_o` are low, all enables are low and all `srst_no` bits are high. `done_o` rises exactly one cycle after the enables drop, with `hrst_no` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Power-good, synchronous to clk_i |
| soft_req_i | input | N_SRST | Soft reset request, one bit per channel |
| strap_i | input | STRAP_W | Strap word, captured at sequence start |
| hrst_no | output | 1 | Active-low hard reset |
| srst_no | output | N_SRST | Active-low soft reset outputs |
| strap_val_o | output | STRAP_W | Captured strap values |
| strap_oe_o | output | STRAP_W | Per-bit strap output enable |
| done_o | output | 1 | Sequence complete |

## Verification
The sequence is exercised with random strap words while `strap_i` is scrambled every cycle during the drive phases. This separates a captured word from one that is re-sampled late. Every phase length is measured against the rising edge of `hrst_no`, so setup, hold and release counts that are off by one cycle show up. Power-good is dropped at random points, including after release and after completion, to tell an immediate combinational pull from a registered one and to confirm a clean restart. Soft requests are sent before completion, during a running pulse, and on both channels together, to tell accepted requests from ignored ones.

// File: rtl/por_pkg.sv
// Package: shared state type and helpers for the power-on reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package por_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE_PLL,
        ST_DRIVE_CFG,
        ST_RELEASE,
        ST_HOLD,
        ST_TRISTATE,
        ST_DONE
    } por_state_e;

    // Larger of two integers, used for derived lengths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/por_us_timer.sv
// Module: microsecond timebase. A prescaler divides the clock by CYC_PER_US
// and a counter counts the resulting microsecond ticks. While run_i is high it
// counts; expire_o pulses on the last clock of the US_TARGET-th microsecond.
// Assumes: run_i is held high continuously until expire_o; dropping run_i clears it.
module por_us_timer #(
    parameter int CYC_PER_US = 100,
    parameter int US_TARGET  = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);
    localparam int PRE_W = $clog2(CYC_PER_US + 1);
    localparam int US_W  = $clog2(US_TARGET + 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             tick;

    // Tick on the last clock of every microsecond.
    always_comb begin
        tick = run_i && (pre_q == PRE_W'(CYC_PER_US - 1));
    end

    // Prescaler and microsecond counter, cleared whenever the timer is idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            us_q  <= us_q + US_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Expiry when the final microsecond completes.
    always_comb begin
        expire_o = tick && (us_q == US_W'(US_TARGET - 1));
    end

endmodule

// File: rtl/por_seq_fsm.sv
// Module: sequencing state machine. It walks IDLE, DRIVE_PLL, DRIVE_CFG,
// RELEASE, HOLD, TRISTATE, DONE. DRIVE_PLL ends on the microsecond timer;
// DRIVE_CFG and HOLD are counted in clocks. Low power-good returns it to IDLE.
// Assumes: pwr_good_i is synchronous to clk_i; OE_DROP_CLKS >= 2; CFG_SETUP_CLKS >= 1.
module por_seq_fsm
    import por_pkg::*;
#(
    parameter int CFG_SETUP_CLKS = 4,
    parameter int OE_DROP_CLKS   = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_good_i,
    input  logic       pll_wait_done_i,
    output por_state_e state_o,
    output logic       start_o
);
    localparam int HOLD_LEN = OE_DROP_CLKS - 1;
    localparam int CNT_MAX  = imax(CFG_SETUP_CLKS, imax(HOLD_LEN, 1));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    por_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cfg_last, hold_last;

    // End-of-phase detects for the clock-counted phases.
    always_comb begin
        cfg_last  = (cnt_q == CNT_W'(CFG_SETUP_CLKS - 1));
        hold_last = (cnt_q == CNT_W'(HOLD_LEN - 1));
    end

    // Next-state decision, with power loss taking priority.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (pwr_good_i)      state_d = ST_DRIVE_PLL;
            ST_DRIVE_PLL: if (pll_wait_done_i) state_d = ST_DRIVE_CFG;
            ST_DRIVE_CFG: if (cfg_last)        state_d = ST_RELEASE;
            ST_RELEASE:   state_d = (HOLD_LEN > 0) ? ST_HOLD : ST_TRISTATE;
            ST_HOLD:      if (hold_last)       state_d = ST_TRISTATE;
            ST_TRISTATE:  state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
        if (!pwr_good_i) begin
            state_d = ST_IDLE;
        end
    end

    // State register and in-phase clock counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_DRIVE_CFG || state_q == ST_HOLD) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Outputs: current state and the capture strobe for the strap word.
    always_comb begin
        state_o = state_q;
        start_o = (state_q == ST_IDLE) && pwr_good_i;
    end

endmodule

// File: rtl/por_strap_drive.sv
// Module: strap capture and per-bit enable decode. The strap word is captured
// on the start strobe. PLL bits are enabled from DRIVE_PLL to HOLD and the
// other bits from DRIVE_CFG to HOLD.
// Assumes: PLL group occupies the low PLL_W bits of the bus.
module por_strap_drive
    import por_pkg::*;
#(
    parameter int PLL_W = 4,
    parameter int CFG_W = 12
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   latch_i,
    input  logic [PLL_W+CFG_W-1:0] strap_i,
    input  por_state_e             state_i,
    output logic [PLL_W+CFG_W-1:0] val_o,
    output logic [PLL_W+CFG_W-1:0] oe_o
);
    localparam int STRAP_W = PLL_W + CFG_W;

    logic [STRAP_W-1:0] val_q;
    logic               pll_on, cfg_on;

    // Capture register for the strap word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            val_q <= '0;
        end else if (latch_i) begin
            val_q <= strap_i;
        end
    end

    // Group enables decoded from the sequencer state.
    always_comb begin
        cfg_on = (state_i == ST_DRIVE_CFG) || (state_i == ST_RELEASE) ||
                 (state_i == ST_HOLD);
        pll_on = cfg_on || (state_i == ST_DRIVE_PLL);
    end

    // Per-bit enable: group chosen by bit position.
    for (genvar i = 0; i < STRAP_W; i++) begin : g_oe
        if (i < PLL_W) begin : g_pll
            assign oe_o[i] = pll_on;
        end else begin : g_cfg
            assign oe_o[i] = cfg_on;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/por_soft_pulse.sv
// Module: one soft reset channel. A request sampled while armed and idle
// starts a low pulse of exactly PULSE_CLKS clocks; requests during a pulse
// are dropped. A running pulse finishes even if the arm is withdrawn.
// Assumes: PULSE_CLKS >= 1.
module por_soft_pulse #(
    parameter int PULSE_CLKS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic req_i,
    output logic srst_no
);
    localparam int CW = $clog2(PULSE_CLKS + 1);

    logic [CW-1:0] cnt_q;

    // Pulse length down-counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end else if (arm_i && req_i) begin
            cnt_q <= CW'(PULSE_CLKS);
        end
    end

    // Output low while the counter runs.
    assign srst_no = (cnt_q == '0);

endmodule

// File: rtl/por_strap_seq.sv
// Module: top of the power-on reset and strap sequencer. It ties together the
// microsecond timer, state machine, strap driver and soft reset channels.
// Hard reset is gated by power-good so a loss takes effect in the same cycle.
// Assumes: all inputs synchronous to clk_i; straps are tri-stated by the pads
// wherever strap_oe_o is low.
module por_strap_seq
    import por_pkg::*;
#(
    parameter int CYC_PER_US     = 100,
    parameter int HRST_US        = 100,
    parameter int PLL_SETUP_US   = 100,
    parameter int CFG_SETUP_CLKS = 4,
    parameter int OE_DROP_CLKS   = 3,
    parameter int SRST_CLKS      = 3,
    parameter int PLL_W          = 4,
    parameter int CFG_W          = 12,
    parameter int N_SRST         = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pwr_good_i,
    input  logic [N_SRST-1:0]      soft_req_i,
    input  logic [PLL_W+CFG_W-1:0] strap_i,
    output logic                   hrst_no,
    output logic [N_SRST-1:0]      srst_no,
    output logic [PLL_W+CFG_W-1:0] strap_val_o,
    output logic [PLL_W+CFG_W-1:0] strap_oe_o,
    output logic                   done_o
);
    localparam int STRAP_W = PLL_W + CFG_W;
    localparam int US_WAIT = imax(HRST_US, PLL_SETUP_US);

    por_state_e state;
    logic       start, pll_wait_done, timer_run, hrst_off, in_done;

    // Timer runs only while the PLL straps are being set up.
    always_comb begin
        timer_run = (state == ST_DRIVE_PLL);
    end

    por_us_timer #(
        .CYC_PER_US (CYC_PER_US),
        .US_TARGET  (US_WAIT)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (timer_run),
        .expire_o (pll_wait_done)
    );

    por_seq_fsm #(
        .CFG_SETUP_CLKS (CFG_SETUP_CLKS),
        .OE_DROP_CLKS   (OE_DROP_CLKS)
    ) u_fsm (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .pwr_good_i      (pwr_good_i),
        .pll_wait_done_i (pll_wait_done),
        .state_o         (state),
        .start_o         (start)
    );

    por_strap_drive #(
        .PLL_W (PLL_W),
        .CFG_W (CFG_W)
    ) u_drive (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .latch_i (start),
        .strap_i (strap_i),
        .state_i (state),
        .val_o   (strap_val_o),
        .oe_o    (strap_oe_o)
    );

    // Hard reset release phases and completion decode.
    always_comb begin
        hrst_off = (state == ST_RELEASE) || (state == ST_HOLD) ||
                   (state == ST_TRISTATE) || (state == ST_DONE);
        in_done  = (state == ST_DONE);
    end

    // One pulse generator per soft reset output.
    for (genvar c = 0; c < N_SRST; c++) begin : g_srst
        por_soft_pulse #(
            .PULSE_CLKS (SRST_CLKS)
        ) u_pulse (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .arm_i   (in_done),
            .req_i   (soft_req_i[c]),
            .srst_no (srst_no[c])
        );
    end

    // Outputs: hard reset gated by power-good, completion flag.
    always_comb begin
        hrst_no = hrst_off && pwr_good_i;
        done_o  = in_done;
    end

    logic [STRAP_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/por_strap_seq_chk.sv
// Module: checker for por_strap_seq, attached by bind. Window lengths are
// measured with counters rather than long $past chains.
// Assumes: same parameters as the bound instance.
module por_strap_seq_chk #(
    parameter int CYC_PER_US     = 100,
    parameter int HRST_US        = 100,
    parameter int PLL_SETUP_US   = 100,
    parameter int CFG_SETUP_CLKS = 4,
    parameter int OE_DROP_CLKS   = 3,
    parameter int SRST_CLKS      = 3,
    parameter int PLL_W          = 4,
    parameter int CFG_W          = 12,
    parameter int N_SRST         = 2
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   pwr_good_i,
    input logic [N_SRST-1:0]      soft_req_i,
    input logic [PLL_W+CFG_W-1:0] strap_i,
    input logic                   hrst_no,
    input logic [N_SRST-1:0]      srst_no,
    input logic [PLL_W+CFG_W-1:0] strap_val_o,
    input logic [PLL_W+CFG_W-1:0] strap_oe_o,
    input logic                   done_o
);
    localparam int STRAP_W = PLL_W + CFG_W;

    int low_run, pll_run, cfg_run, since_rel;
    int s_run [N_SRST];
    logic pll_all, cfg_all;

    always_comb begin
        pll_all = &strap_oe_o[PLL_W-1:0];
        cfg_all = &strap_oe_o[STRAP_W-1:PLL_W];
    end

    // Run-length counters for the reset and strap windows.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            low_run <= 0; pll_run <= 0; cfg_run <= 0; since_rel <= 0;
        end else begin
            low_run   <= (pwr_good_i && !hrst_no) ? low_run + 1 : 0;
            pll_run   <= pll_all ? pll_run + 1 : 0;
            cfg_run   <= cfg_all ? cfg_run + 1 : 0;
            since_rel <= hrst_no ? ((since_rel < 1000) ? since_rel + 1 : since_rel) : 0;
        end
    end

    assert_hrst_min_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hrst_no) |-> (low_run >= HRST_US * CYC_PER_US));

    assert_pll_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hrst_no) |-> (pll_run >= PLL_SETUP_US * CYC_PER_US));

    assert_cfg_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hrst_no) |-> (cfg_run >= CFG_SETUP_CLKS));

    assert_hold_now_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hrst_no) |-> (strap_oe_o == '1));

    assert_hold_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(hrst_no) && pwr_good_i) |=> (!pwr_good_i || strap_oe_o == '1));

    assert_tristate_deadline_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hrst_no && since_rel >= OE_DROP_CLKS) |-> (strap_oe_o == '0));

    assert_pwr_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_good_i |-> !hrst_no);

    assert_pwr_loss_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_good_i |=> (strap_oe_o == '0));

    assert_vals_steady_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((strap_val_o ^ $past(strap_val_o)) & strap_oe_o & $past(strap_oe_o)) == '0);

    assert_done_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && pwr_good_i) |-> (hrst_no && strap_oe_o == '0));

    for (genvar c = 0; c < N_SRST; c++) begin : g_chk
        // Low-run counter for this soft reset channel.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) s_run[c] <= 0;
            else         s_run[c] <= !srst_no[c] ? s_run[c] + 1 : 0;
        end

        assert_srst_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(srst_no[c]) |-> (s_run[c] == SRST_CLKS));

        assert_srst_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!done_o && srst_no[c]) |=> srst_no[c]);
    end

    logic unused_c;
    assign unused_c = ^{soft_req_i, strap_i, cfg_run};

endmodule

bind por_strap_seq por_strap_seq_chk #(
    .CYC_PER_US     (CYC_PER_US),
    .HRST_US        (HRST_US),
    .PLL_SETUP_US   (PLL_SETUP_US),
    .CFG_SETUP_CLKS (CFG_SETUP_CLKS),
    .OE_DROP_CLKS   (OE_DROP_CLKS),
    .SRST_CLKS      (SRST_CLKS),
    .PLL_W          (PLL_W),
    .CFG_W          (CFG_W),
    .N_SRST         (N_SRST)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .soft_req_i  (soft_req_i),
    .strap_i     (strap_i),
    .hrst_no     (hrst_no),
    .srst_no     (srst_no),
    .strap_val_o (strap_val_o),
    .strap_oe_o  (strap_oe_o),
    .done_o      (done_o)
);

// File: tb/sim_por_strap_seq.sv
module sim_por_strap_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CYC   = 4;
    localparam int H_US  = 10;
    localparam int P_US  = 8;
    localparam int CFGC  = 4;
    localparam int OED   = 3;
    localparam int SRC   = 3;
    localparam int PW    = 3;
    localparam int CW    = 5;
    localparam int NS    = 2;
    localparam int SW    = PW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr = 1'b0;
    logic [NS-1:0] req = '0;
    logic [SW-1:0] strap = '0;
    logic          hrst_n, done;
    logic [NS-1:0] srst_n;
    logic [SW-1:0] val, oe;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_strap_seq #(
        .CYC_PER_US(CYC), .HRST_US(H_US), .PLL_SETUP_US(P_US),
        .CFG_SETUP_CLKS(CFGC), .OE_DROP_CLKS(OED), .SRST_CLKS(SRC),
        .PLL_W(PW), .CFG_W(CW), .N_SRST(NS)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .soft_req_i(req),
        .strap_i(strap), .hrst_no(hrst_n), .srst_no(srst_n),
        .strap_val_o(val), .strap_oe_o(oe), .done_o(done)
    );

    // Expected window lengths, in negedge samples, from the requirements.
    function automatic int wait_cyc();
        return ((H_US > P_US) ? H_US : P_US) * CYC;
    endfunction
    function automatic int exp_low(); return 1 + wait_cyc() + CFGC; endfunction
    function automatic int exp_pll(); return wait_cyc() + CFGC; endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: sampled on the falling edge, measures windows around hrst_n rise.
    int low_run = 0, pll_run = 0, cfg_run = 0, post = 0;
    int rec_low, rec_pll, rec_cfg, drop_idx, done_idx, rises = 0;
    int rec_val, rec_oe_mid, hold_bad;
    bit prev_h = 0;
    int s_run [NS];
    int s_rec [NS];
    int s_fall [NS];
    bit prev_s [NS];

    initial begin
        for (int c = 0; c < NS; c++) begin
            s_run[c] = 0; s_rec[c] = 0; s_fall[c] = 0; prev_s[c] = 1;
        end
    end

    always @(negedge clk) begin
        if (hrst_n && !prev_h) begin
            rec_low = low_run; rec_pll = pll_run; rec_cfg = cfg_run;
            rec_val = int'(val); post = 0; drop_idx = -1; done_idx = -1;
            hold_bad = 0; rises++;
        end
        if (hrst_n) begin
            if (oe != '0 && val != SW'(rec_val)) hold_bad++;
            if (oe == '0 && drop_idx < 0) drop_idx = post;
            if (oe != '0 && oe != '1) hold_bad++;
            if (done && done_idx < 0) done_idx = post;
            post++;
        end
        low_run = (pwr && !hrst_n) ? low_run + 1 : 0;
        pll_run = (&oe[PW-1:0]) ? pll_run + 1 : 0;
        cfg_run = (&oe[SW-1:PW]) ? cfg_run + 1 : 0;
        prev_h  = hrst_n;
        for (int c = 0; c < NS; c++) begin
            if (!srst_n[c] && prev_s[c]) s_fall[c]++;
            if (srst_n[c] && !prev_s[c]) s_rec[c] = s_run[c];
            s_run[c] = !srst_n[c] ? s_run[c] + 1 : 0;
            prev_s[c] = srst_n[c];
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    // Power up with a strap word, scrambling the input afterwards, then check.
    task automatic full_seq(input logic [SW-1:0] v, input bit req_early);
        int r0, f0;
        r0 = rises; f0 = s_fall[0] + s_fall[1];
        strap = v; pwr = 1'b1;
        tick();
        for (int k = 0; k < exp_low() + 20 && !done; k++) begin
            strap = SW'($urandom);
            req = req_early ? NS'($urandom) : '0;
            tick();
        end
        req = '0;
        tick(); tick();
        check(rises == r0 + 1, "R1 release count", rises - r0, 1);
        check(rec_low == exp_low(), "R1 hard reset low window", rec_low, exp_low());
        check(rec_low >= H_US * CYC, "R1 minimum low time", rec_low, H_US * CYC);
        check(rec_pll == exp_pll(), "R2 PLL strap setup", rec_pll, exp_pll());
        check(rec_cfg == CFGC, "R3 other strap setup", rec_cfg, CFGC);
        check(hold_bad == 0 && drop_idx >= 2, "R4 hold after release", drop_idx, OED);
        check(drop_idx == OED && drop_idx <= 5, "R5 tristate point", drop_idx, OED);
        check(rec_val == int'(v), "R9 captured strap word", rec_val, int'(v));
        check(done_idx == OED + 1, "R10 done timing", done_idx, OED + 1);
        if (req_early)
            check(s_fall[0] + s_fall[1] == f0, "R8 request before done", s_fall[0] + s_fall[1] - f0, 0);
    endtask

    task automatic soft_test(input logic [NS-1:0] m);
        int f [NS];
        for (int c = 0; c < NS; c++) f[c] = s_fall[c];
        req = m; tick();
        req = '0; tick();
        req = m; tick();   // during the pulse: dropped
        req = '0;
        repeat (SRC + 3) tick();
        for (int c = 0; c < NS; c++) begin
            if (m[c]) begin
                check(s_fall[c] == f[c] + 1, "R8 request during pulse", s_fall[c] - f[c], 1);
                check(s_rec[c] == SRC, "R6 soft reset width", s_rec[c], SRC);
            end else begin
                check(s_fall[c] == f[c], "R6 unrequested channel quiet", s_fall[c] - f[c], 0);
            end
        end
    endtask

    task automatic pwr_drop_at(input int k);
        pwr = 1'b1; tick();
        repeat (k) tick();
        pwr = 1'b0; #1;
        check(hrst_n == 1'b0, "R7 hard reset same cycle", int'(hrst_n), 0);
        tick();
        check(oe == '0, "R7 enables off next cycle", int'(oe), 0);
        tick();
    endtask

    initial begin
        void'($urandom(32'h1D2C));
        repeat (3) tick();
        check(hrst_n == 1'b0 && done == 1'b0, "R10 reset hard reset and done", int'({hrst_n, done}), 0);
        check(oe == '0, "R10 reset enables", int'(oe), 0);
        check(srst_n == '1, "R10 reset soft outputs", int'(srst_n), 3);
        rst_n = 1'b1;
        tick();
        // directed: early soft requests, then both channel patterns
        full_seq(8'hA5, 1'b1);
        soft_test(2'b01);
        soft_test(2'b11);
        // directed: loss right after release, then clean restart
        pwr = 1'b0; tick(); tick();
        pwr_drop_at(exp_low() + 1);
        full_seq(8'h3C, 1'b0);
        pwr_drop_at(2);
        // random mix
        for (int it = 0; it < 20; it++) begin
            full_seq(SW'($urandom), 1'($urandom));
            if ($urandom_range(0, 1) == 1) soft_test(NS'($urandom_range(1, 3)));
            pwr = 1'b0; tick(); tick();
            pwr_drop_at($urandom_range(0, exp_low() + 8));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule